// File: doc/BRIEF.md
# Branch Line Cache

This block is a small line store that sits between an instruction prefetch buffer and the flash banks. It keeps 256-bit lines in a two-way set-associative array of sixteen sets. It is never loaded by a dedicated access. Any line that the flash returns through the fill port is copied into it during the same transfer that hands the line to the prefetch buffer.

The block consults its contents only when the fetch stream breaks. A branch target, or any other fetch that is not the next sequential line, is presented on the request port with the sequential flag low. On a hit, the stored line is driven to the prefetch buffer in the following cycle, which gives one wait state. On a miss, a flash read for that line is issued and the block waits for the line on the fill port. A sequential request always goes straight to flash. The cache enable bit is off after reset. The cache works only while the cache enable and the prefetch enable are both set. With prefetch disabled, nothing is stored and every lookup misses.

The controller has four states. ST_IDLE accepts requests. ST_HIT presents a cached line for one cycle. ST_ISSUE drives the flash read for one cycle. ST_WAIT holds until a fill arrives. The transitions are:
- ST_IDLE to ST_HIT on a discontinuous hit.
- ST_IDLE to ST_ISSUE on a miss or a sequential request.
- ST_HIT to ST_IDLE always.
- ST_ISSUE to ST_WAIT always.
- ST_WAIT to ST_IDLE when fill_valid is high.

Top module: `branch_line_cache`

## Requirements
- R1: After reset, req_ready is 1, pb_valid and fl_req are 0, and every entry is invalid, so the first discontinuous lookup misses.
- R2: A discontinuous request (req_seq=0) accepted in ST_IDLE that hits raises pb_valid for exactly the next cycle, carrying the stored line on pb_data, with fl_req low.
- R3: A discontinuous request that misses raises fl_req for exactly the next cycle, with fl_line equal to the requested line address.
- R4: A sequential request (req_seq=1) performs no lookup and always raises fl_req in the next cycle, even when the line is cached.
- R5: A fill (fill_valid=1) while both enables are set stores fill_data under fill_line, and a later discontinuous request for that line hits with that data.
- R6: Each set holds two lines. The set index is line address bits [3:0] and the tag is the remaining upper bits. Two lines with the same index and different tags can both hit.
- R7: A fill into a set whose two ways are valid and do not match replaces the least recently used way. Both hits and fills mark a way as most recently used. A fill whose tag matches a valid way overwrites that way.
- R8: While cache_en is 0, every lookup misses. Clearing cache_en invalidates every entry, so lines stored earlier miss once it is set again.
- R9: While pf_en is 0, fills are not stored and every lookup misses, even with cache_en set.
- R10: In ST_ISSUE and ST_WAIT, req_ready is 0 and req_valid is ignored. The block returns to ST_IDLE on the cycle after fill_valid is seen in ST_WAIT.
- R11: pb_valid and fl_req are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cache_en | input | 1 | Cache enable; clearing it invalidates all entries |
| pf_en | input | 1 | Prefetch enable; the cache is inert while low |
| req_valid | input | 1 | Fetch request strobe |
| req_seq | input | 1 | 1 = sequential line fetch, 0 = discontinuity |
| req_line | input | LA_W (19) | Requested line address (byte address without the 5 offset bits) |
| req_ready | output | 1 | Request accepted this cycle when high |
| pb_valid | output | 1 | Cached line delivered to the prefetch buffer |
| pb_data | output | 256 | Cached line contents |
| fl_req | output | 1 | Flash line read request |
| fl_line | output | LA_W (19) | Line address for the flash read |
| fill_valid | input | 1 | Line returned from flash |
| fill_line | input | LA_W (19) | Line address of the returned line |
| fill_data | input | 256 | Returned line contents |

## Verification
On every cycle the assertions check the following. A hit pulse lasts exactly one cycle and never coincides with a flash read. A sequential request always turns into a flash read. The block is busy after a flash read. A hit can only follow a cycle in which both enables were set. Only the bench's scenarios can show the following. The line returned on a hit is the one filled earlier. Replacement follows recency across sequences of hits and fills. Clearing the enable wipes the stored lines. Prefetch-off fills leave no trace. The bench predicts each of these with a reference model of tags, valid bits and recency.

// File: rtl/blc_pkg.sv
package blc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HIT   = 2'd1,
        ST_ISSUE = 2'd2,
        ST_WAIT  = 2'd3
    } blc_state_e;
endpackage

// File: rtl/blc_way.sv
module blc_way #(
    parameter int TAG_W  = 10,
    parameter int IDX_W  = 4,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [LINE_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              wr_match,
    output logic              wr_vld,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   vld;
    logic [TAG_W-1:0]  tags [SETS];
    logic [LINE_W-1:0] lines [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (clr) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tags[wr_idx]  <= wr_tag;
            lines[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_hit   = vld[rd_idx] && (tags[rd_idx] == rd_tag);
        rd_data  = lines[rd_idx];
        wr_vld   = vld[wr_idx];
        wr_match = vld[wr_idx] && (tags[wr_idx] == wr_tag);
    end
endmodule

// File: rtl/blc_lru.sv
module blc_lru #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_upd,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             hit_way,
    input  logic             fill_upd,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_way,
    output logic             victim
);
    localparam int SETS = 1 << IDX_W;

    // Each bit names the least recently used way of its set.
    logic [SETS-1:0] lru;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru <= '0;
        end else if (fill_upd) begin
            lru[fill_idx] <= ~fill_way;
        end else if (hit_upd) begin
            lru[hit_idx] <= ~hit_way;
        end
    end

    assign victim = lru[fill_idx];
endmodule

// File: rtl/blc_fsm.sv
module blc_fsm
    import blc_pkg::*;
#(
    parameter int LA_W   = 19,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_seq,
    input  logic [LA_W-1:0]   req_line,
    input  logic              lookup_hit,
    input  logic [LINE_W-1:0] hit_data,
    input  logic              fill_valid,
    output logic              accept_hit,
    output logic              req_ready,
    output logic              pb_valid,
    output logic [LINE_W-1:0] pb_data,
    output logic              fl_req,
    output logic [LA_W-1:0]   fl_line
);
    blc_state_e state, next;

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:  if (req_valid) next = (!req_seq && lookup_hit) ? ST_HIT : ST_ISSUE;
            ST_HIT:   next = ST_IDLE;
            ST_ISSUE: next = ST_WAIT;
            ST_WAIT:  if (fill_valid) next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pb_data <= '0;
            fl_line <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            pb_data <= hit_data;
            fl_line <= req_line;
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        pb_valid   = 1'b0;
        fl_req     = 1'b0;
        accept_hit = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready  = 1'b1;
                accept_hit = req_valid && !req_seq && lookup_hit;
            end
            ST_HIT:   pb_valid = 1'b1;
            ST_ISSUE: fl_req   = 1'b1;
            ST_WAIT:  ;
        endcase
    end
endmodule

// File: rtl/branch_line_cache.sv
module branch_line_cache #(
    parameter int ADDR_W = 24,
    parameter int LINE_W = 256,
    parameter int SETS   = 16,
    parameter int OFF_W  = $clog2(LINE_W / 8),
    parameter int LA_W   = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              pf_en,
    input  logic              req_valid,
    input  logic              req_seq,
    input  logic [LA_W-1:0]   req_line,
    output logic              req_ready,
    output logic              pb_valid,
    output logic [LINE_W-1:0] pb_data,
    output logic              fl_req,
    output logic [LA_W-1:0]   fl_line,
    input  logic              fill_valid,
    input  logic [LA_W-1:0]   fill_line,
    input  logic [LINE_W-1:0] fill_data
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LA_W - IDX_W;
    localparam int WAYS  = 2;

    logic              active;
    logic [WAYS-1:0]   way_hit, way_match, way_vld, way_wr;
    logic [LINE_W-1:0] way_data [WAYS];
    logic              lookup_hit, hit_way, fill_way, victim, accept_hit, fill_upd;
    logic [LINE_W-1:0] hit_data;

    assign active = cache_en && pf_en;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        blc_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!cache_en),
            .rd_idx   (req_line[IDX_W-1:0]),
            .rd_tag   (req_line[LA_W-1:IDX_W]),
            .rd_hit   (way_hit[w]),
            .rd_data  (way_data[w]),
            .wr_idx   (fill_line[IDX_W-1:0]),
            .wr_tag   (fill_line[LA_W-1:IDX_W]),
            .wr_match (way_match[w]),
            .wr_vld   (way_vld[w]),
            .wr_en    (way_wr[w]),
            .wr_data  (fill_data)
        );
    end

    always_comb begin
        lookup_hit = active && (|way_hit);
        hit_way    = way_hit[1];
        hit_data   = hit_way ? way_data[1] : way_data[0];
        fill_upd   = fill_valid && active;
        if (way_match[0])      fill_way = 1'b0;
        else if (way_match[1]) fill_way = 1'b1;
        else if (!way_vld[0])  fill_way = 1'b0;
        else if (!way_vld[1])  fill_way = 1'b1;
        else                   fill_way = victim;
        way_wr[0] = fill_upd && !fill_way;
        way_wr[1] = fill_upd && fill_way;
    end

    blc_lru #(.IDX_W(IDX_W)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_upd  (accept_hit),
        .hit_idx  (req_line[IDX_W-1:0]),
        .hit_way  (hit_way),
        .fill_upd (fill_upd),
        .fill_idx (fill_line[IDX_W-1:0]),
        .fill_way (fill_way),
        .victim   (victim)
    );

    blc_fsm #(.LA_W(LA_W), .LINE_W(LINE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_seq    (req_seq),
        .req_line   (req_line),
        .lookup_hit (lookup_hit),
        .hit_data   (hit_data),
        .fill_valid (fill_valid),
        .accept_hit (accept_hit),
        .req_ready  (req_ready),
        .pb_valid   (pb_valid),
        .pb_data    (pb_data),
        .fl_req     (fl_req),
        .fl_line    (fl_line)
    );
endmodule

// File: rtl/branch_line_cache_chk.sv
module branch_line_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic cache_en,
    input logic pf_en,
    input logic req_valid,
    input logic req_seq,
    input logic req_ready,
    input logic pb_valid,
    input logic fl_req
);
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |=> !pb_valid); // R2

    AST_NO_HIT_WITH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(pb_valid && fl_req)); // R11

    AST_SEQ_GOES_TO_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_seq) |=> fl_req); // R4

    AST_BUSY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |=> !req_ready); // R10

    AST_HIT_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(cache_en && pf_en)) |=> !pb_valid); // R9

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |=> !fl_req); // R3
endmodule

bind branch_line_cache branch_line_cache_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cache_en  (cache_en),
    .pf_en     (pf_en),
    .req_valid (req_valid),
    .req_seq   (req_seq),
    .req_ready (req_ready),
    .pb_valid  (pb_valid),
    .fl_req    (fl_req)
);

// File: tb/branch_line_cache_test.sv
`timescale 1ns/1ps
module branch_line_cache_test;
    localparam int LA_W = 19;
    localparam int LW   = 256;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cache_en = 1'b0, pf_en = 1'b0;
    logic req_valid = 1'b0, req_seq = 1'b0;
    logic [LA_W-1:0] req_line = '0, fill_line = '0;
    logic fill_valid = 1'b0;
    logic [LW-1:0] fill_data = '0;
    logic req_ready, pb_valid, fl_req;
    logic [LW-1:0] pb_data;
    logic [LA_W-1:0] fl_line;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // reference model
    bit       mv [2][16];
    int       mt [2][16];
    bit       ml [16];

    always #2 clk = ~clk;

    branch_line_cache uut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en), .pf_en(pf_en),
        .req_valid(req_valid), .req_seq(req_seq), .req_line(req_line),
        .req_ready(req_ready), .pb_valid(pb_valid), .pb_data(pb_data),
        .fl_req(fl_req), .fl_line(fl_line), .fill_valid(fill_valid),
        .fill_line(fill_line), .fill_data(fill_data)
    );

    function automatic logic [LW-1:0] mk_line(logic [LA_W-1:0] a);
        logic [LW-1:0] d;
        for (int k = 0; k < 8; k++) d[k*32 +: 32] = {13'(k * 37), a} ^ 32'h5A3C_0000;
        return d;
    endfunction

    function automatic bit m_lookup(logic [LA_W-1:0] a);
        int i = int'(a[3:0]);
        int t = int'(a[LA_W-1:4]);
        if (!(cache_en && pf_en)) return 1'b0;
        for (int w = 0; w < 2; w++) begin
            if (mv[w][i] && mt[w][i] == t) begin
                ml[i] = (w == 0);
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    function automatic void m_fill(logic [LA_W-1:0] a);
        int i = int'(a[3:0]);
        int t = int'(a[LA_W-1:4]);
        int w;
        if (!(cache_en && pf_en)) return;
        if (mv[0][i] && mt[0][i] == t)      w = 0;
        else if (mv[1][i] && mt[1][i] == t) w = 1;
        else if (!mv[0][i])                 w = 0;
        else if (!mv[1][i])                 w = 1;
        else                                w = int'(ml[i]);
        mv[w][i] = 1'b1;
        mt[w][i] = t;
        ml[i] = (w == 0);
    endfunction

    function automatic void m_clear();
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 16; i++) mv[w][i] = 1'b0;
    endfunction

    task automatic chk(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic set_en(bit ce, bit pe);
        @(negedge clk);
        cache_en = ce;
        pf_en = pe;
        if (!ce) m_clear();
    endtask

    // one request; optionally probe that requests are ignored while busy
    task automatic do_req(logic [LA_W-1:0] a, bit seq, bit probe, string r);
        bit eh;
        @(negedge clk);
        chk(req_ready == 1'b1, r, "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_line = a; req_seq = seq;
        @(negedge clk);
        req_valid = 1'b0;
        eh = !seq && m_lookup(a);
        chk(pb_valid == eh, r, "pb_valid", 64'(pb_valid), 64'(eh));
        chk(fl_req == !eh, r, "fl_req", 64'(fl_req), 64'(!eh));
        if (eh) begin
            chk(pb_data == mk_line(a), r, "pb_data", pb_data[63:0], mk_line(a) >> 0);
        end else begin
            chk(fl_line == a, r, "fl_line", 64'(fl_line), 64'(a));
            @(negedge clk);
            chk(req_ready == 1'b0 && fl_req == 1'b0, "R10", "busy in wait",
                64'({req_ready, fl_req}), 64'd0);
            if (probe) begin
                req_valid = 1'b1; req_line = a; req_seq = 1'b0;
                @(negedge clk);
                req_valid = 1'b0;
                chk(!pb_valid && !fl_req && !req_ready, "R10", "request ignored while busy",
                    64'({pb_valid, fl_req, req_ready}), 64'd0);
            end
            fill_valid = 1'b1; fill_line = a; fill_data = mk_line(a);
            @(negedge clk);
            fill_valid = 1'b0;
            m_fill(a);
            chk(req_ready == 1'b1, "R10", "idle after fill", 64'(req_ready), 64'd1);
        end
    endtask

    function automatic logic [LA_W-1:0] la(int tag, int idx);
        return LA_W'((tag << 4) | idx);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_clear();
        for (int i = 0; i < 16; i++) ml[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !pb_valid && !fl_req, "R1", "reset outputs",
            64'({req_ready, pb_valid, fl_req}), 64'b100);
        set_en(1'b1, 1'b1);
        do_req(la(7, 2), 1'b0, 1'b0, "R1");        // first lookup misses
        do_req(la(7, 2), 1'b0, 1'b0, "R2");        // now hits
        do_req(la(7, 2), 1'b0, 1'b0, "R5");
        do_req(la(7, 2), 1'b1, 1'b0, "R4");        // sequential: flash anyway
        do_req(la(9, 3), 1'b0, 1'b1, "R3");        // miss, busy probe
        // two ways and recency on set 5
        do_req(la(1, 5), 1'b0, 1'b0, "R3");
        do_req(la(2, 5), 1'b0, 1'b0, "R6");
        do_req(la(1, 5), 1'b0, 1'b0, "R6");
        do_req(la(2, 5), 1'b0, 1'b0, "R6");
        do_req(la(3, 5), 1'b0, 1'b0, "R7");        // evicts tag 1
        do_req(la(2, 5), 1'b0, 1'b0, "R7");
        do_req(la(1, 5), 1'b0, 1'b0, "R7");        // miss, evicts tag 3
        do_req(la(3, 5), 1'b0, 1'b0, "R7");
        // cache disabled
        set_en(1'b0, 1'b1);
        do_req(la(2, 5), 1'b0, 1'b0, "R8");
        set_en(1'b1, 1'b1);
        do_req(la(7, 2), 1'b0, 1'b0, "R8");        // wiped
        // prefetch disabled
        set_en(1'b1, 1'b0);
        do_req(la(4, 9), 1'b0, 1'b0, "R9");
        do_req(la(7, 2), 1'b0, 1'b0, "R9");
        set_en(1'b1, 1'b1);
        do_req(la(4, 9), 1'b0, 1'b0, "R9");        // not stored
        // constrained random
        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 3)      set_en(1'b0, pf_en);
            else if (r < 8) set_en(1'b1, pf_en);
            else if (r < 11) set_en(cache_en, !pf_en);
            do_req(la(int'($urandom_range(1, 3)), int'($urandom_range(0, 3))),
                   ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) == 0), "R5");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule